// File: doc/BRIEF.md
# Table-Driven Add-or-Load Counter Slice

This block applies one of sixteen fixed operations to a narrow unsigned value. A 4-bit select chooses the operation. Compile-time parameters set, for each of the sixteen entries, whether the entry adds a signed integer constant to the operand or replaces the operand with that constant. All arithmetic is taken modulo 2^WIDTH, so a sum that overflows wraps with no flag.

The unit produces its result combinationally on `res_comb`. It also holds the value in an accumulator register `acc_q`, which has an update enable and a synchronous reset. A feedback select chooses the operand: either the external `src_val` or the register's own contents. With feedback selected, the block works as a counter that steps by any of the tabled amounts or jumps to any tabled value. A typical use is a running-balance tracker that moves by small signed steps each cycle.

Negative constants are applied by adding the inverted magnitude with a carry-in of one. Load entries use the same path with the operand forced to zero. A constant that does not fit the width is reduced to its low WIDTH bits in two's complement.

Top module: `tbl_addload_unit`

## Requirements
- R1: `res_comb` reflects, in the same cycle, the table entry indexed by `op_sel` (entries 0 to 15) applied to the selected operand.
- R2: For an add entry with a non-negative constant, `res_comb` equals (operand + constant) mod 2^WIDTH.
- R3: For an add entry with a negative constant, `res_comb` equals the operand minus the constant's magnitude, mod 2^WIDTH (for example, 0 plus -1 gives all ones).
- R4: For a load entry (bit i of `OP_LOAD_MASK` set), `res_comb` equals the constant mod 2^WIDTH whatever the operand is.
- R5: A sum that passes 2^WIDTH - 1 wraps silently; for example, all ones plus 1 gives 0.
- R6: The operand is `src_val` when `fb_sel` is 0 and `acc_q` when `fb_sel` is 1.
- R7: At a rising clock edge with `rst` low, `acc_q` takes `res_comb` if `upd_en` is 1 and keeps its value if `upd_en` is 0.
- R8: When `rst` is high at a rising edge, `acc_q` becomes 0, even if `upd_en` is also high.
- R9: Constants outside the WIDTH range, whether added or loaded, act through their low WIDTH bits in two's complement (for example, at WIDTH 8, loading 300 gives 44 and adding 255 acts as subtracting 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the accumulator |
| upd_en | input | 1 | Accumulator update enable |
| fb_sel | input | 1 | 1: operand is the accumulator; 0: operand is src_val |
| op_sel | input | 4 | Index of the table entry to apply |
| src_val | input | WIDTH | External operand |
| res_comb | output | WIDTH | Combinational result of the selected entry |
| acc_q | output | WIDTH | Registered accumulator |

## Verification
Two functions can meet in one cycle: reset and update. A reset can arrive while `upd_en` is high and the selected entry would change the accumulator. The bench drives reset with the update enable asserted and a non-zero result pending, and it expects `acc_q` to read zero after that edge. The counter's wrap and a load entry can also fall on the same feedback cycle. Random runs with feedback on and random enables check each step against a model register kept in the bench, using two different parameter tables and widths.

// File: rtl/addload_pkg.sv
package addload_pkg;

  typedef enum logic {
    OP_ADD  = 1'b0,
    OP_LOAD = 1'b1
  } op_kind_e;

  localparam int NUM_OPS = 16;
  localparam int SEL_W   = $clog2(NUM_OPS);

endpackage

// File: rtl/addload_table.sv
module addload_table
  import addload_pkg::*;
#(
  parameter int          WIDTH        = 5,
  parameter logic [15:0] OP_LOAD_MASK = 16'h0000,
  parameter int          OP_CONST [16] = '{default: 0}
) (
  input  logic [SEL_W-1:0] sel,
  output op_kind_e         kind,
  output logic             neg,
  output logic [WIDTH-1:0] mag
);

  logic [WIDTH-1:0] mag_tbl  [NUM_OPS];
  logic             neg_tbl  [NUM_OPS];
  logic             load_tbl [NUM_OPS];

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_ent
    localparam int CV = OP_CONST[i];
    localparam int AV = (CV < 0) ? -CV : CV;
    assign mag_tbl[i]  = WIDTH'(AV);
    assign neg_tbl[i]  = (CV < 0);
    assign load_tbl[i] = OP_LOAD_MASK[i];
  end

  always_comb begin
    kind = load_tbl[sel] ? OP_LOAD : OP_ADD;
    neg  = neg_tbl[sel];
    mag  = mag_tbl[sel];
  end

endmodule

// File: rtl/addload_adder.sv
module addload_adder #(
  parameter int WIDTH = 5
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] mag,
  input  logic             neg,
  output logic [WIDTH-1:0] sum
);

  logic [WIDTH-1:0] b_eff;

  always_comb begin
    b_eff = neg ? ~mag : mag;
    sum   = a + b_eff + WIDTH'(neg);
  end

endmodule

// File: rtl/addload_reg.sv
module addload_reg #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/tbl_addload_unit.sv
module tbl_addload_unit
  import addload_pkg::*;
#(
  parameter int          WIDTH        = 5,
  parameter logic [15:0] OP_LOAD_MASK = 16'h7800,
  parameter int          OP_CONST [16] = '{0, 1, 2, 3, 4, 5, -1, -2,
                                           -3, -4, -5, 0, 1, -1, 15, 16}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic             fb_sel,
  input  logic [3:0]       op_sel,
  input  logic [WIDTH-1:0] src_val,
  output logic [WIDTH-1:0] res_comb,
  output logic [WIDTH-1:0] acc_q
);

  op_kind_e         kind;
  logic             neg;
  logic [WIDTH-1:0] mag;
  logic [WIDTH-1:0] opnd;
  logic [WIDTH-1:0] a_gated;

  addload_table #(
    .WIDTH(WIDTH),
    .OP_LOAD_MASK(OP_LOAD_MASK),
    .OP_CONST(OP_CONST)
  ) table_i (
    .sel (op_sel),
    .kind(kind),
    .neg (neg),
    .mag (mag)
  );

  always_comb begin
    opnd    = fb_sel ? acc_q : src_val;
    a_gated = (kind == OP_LOAD) ? '0 : opnd;
  end

  addload_adder #(.WIDTH(WIDTH)) adder_i (
    .a  (a_gated),
    .mag(mag),
    .neg(neg),
    .sum(res_comb)
  );

  addload_reg #(.WIDTH(WIDTH)) acc_i (
    .clk(clk),
    .rst(rst),
    .en (upd_en),
    .d  (res_comb),
    .q  (acc_q)
  );

endmodule

// File: rtl/addload_chk.sv
module addload_chk #(
  parameter int          WIDTH        = 5,
  parameter logic [15:0] OP_LOAD_MASK = 16'h0000,
  parameter int          OP_CONST [16] = '{default: 0}
) (
  input logic             clk,
  input logic             rst,
  input logic             upd_en,
  input logic             fb_sel,
  input logic [3:0]       op_sel,
  input logic [WIDTH-1:0] src_val,
  input logic [WIDTH-1:0] res_comb,
  input logic [WIDTH-1:0] acc_q
);

  logic [WIDTH-1:0] opnd_c;
  logic [WIDTH-1:0] cst_c;
  assign opnd_c = fb_sel ? acc_q : src_val;
  assign cst_c  = WIDTH'(OP_CONST[op_sel]);

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
    OP_LOAD_MASK[op_sel] |-> res_comb == cst_c); // R4

  AST_ADD_VALUE: assert property (@(posedge clk) disable iff (rst)
    !OP_LOAD_MASK[op_sel] |-> res_comb == WIDTH'(opnd_c + cst_c)); // R2

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> acc_q == '0); // R8

  AST_UPDATE: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> acc_q == $past(res_comb)); // R7

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(acc_q)); // R7

endmodule

bind tbl_addload_unit addload_chk #(
  .WIDTH(WIDTH),
  .OP_LOAD_MASK(OP_LOAD_MASK),
  .OP_CONST(OP_CONST)
) chk_i (
  .clk(clk), .rst(rst), .upd_en(upd_en), .fb_sel(fb_sel),
  .op_sel(op_sel), .src_val(src_val), .res_comb(res_comb), .acc_q(acc_q)
);

// File: tb/tbl_addload_unit_tb_top.sv
module tbl_addload_unit_tb_top;

  localparam int          WA = 5;
  localparam logic [15:0] MA = 16'h7800;
  localparam int          CA [16] = '{0, 1, 2, 3, 4, 5, -1, -2,
                                      -3, -4, -5, 0, 1, -1, 15, 16};
  localparam int          WB = 8;
  localparam logic [15:0] MB = 16'h3F00;
  localparam int          CB [16] = '{0, 1, -1, 127, -128, 255, 256, -256,
                                      300, -300, 5, -5, 77, 0, -1, 200};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst, upd_en, fb_sel;
  logic [3:0]    op_sel;
  logic [WA-1:0] src_a, res_a, acc_a;
  logic [WB-1:0] src_b, res_b, acc_b;

  tbl_addload_unit #(.WIDTH(WA), .OP_LOAD_MASK(MA), .OP_CONST(CA)) dut_i (
    .clk(clk), .rst(rst), .upd_en(upd_en), .fb_sel(fb_sel), .op_sel(op_sel),
    .src_val(src_a), .res_comb(res_a), .acc_q(acc_a));

  tbl_addload_unit #(.WIDTH(WB), .OP_LOAD_MASK(MB), .OP_CONST(CB)) dut_b (
    .clk(clk), .rst(rst), .upd_en(upd_en), .fb_sel(fb_sel), .op_sel(op_sel),
    .src_val(src_b), .res_comb(res_b), .acc_q(acc_b));

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [31:0] exp_a = 0;
  logic [31:0] exp_b = 0;

  function automatic logic [31:0] model(int w, bit ld, int c, logic [31:0] opnd);
    int r;
    r = ld ? c : int'(opnd) + c;
    return r & ((1 << w) - 1);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] s, input logic [31:0] sa, input logic [31:0] sb,
                      input bit fb, input bit en, input bit rv, input string tag);
    logic [31:0] ea, eb;
    @(negedge clk);
    op_sel = s; src_a = WA'(sa); src_b = WB'(sb);
    fb_sel = fb; upd_en = en; rst = rv;
    #1;
    ea = model(WA, MA[s], CA[s], fb ? exp_a : (sa & 32'h1F));
    eb = model(WB, MB[s], CB[s], fb ? exp_b : (sb & 32'hFF));
    chk($sformatf("%s comb A sel=%0d", tag, s), 32'(res_a), ea);
    chk($sformatf("%s comb B sel=%0d", tag, s), 32'(res_b), eb);
    @(posedge clk);
    #1;
    exp_a = rv ? 0 : (en ? ea : exp_a);
    exp_b = rv ? 0 : (en ? eb : exp_b);
    chk($sformatf("%s reg A (R7/R8)", tag), 32'(acc_a), exp_a);
    chk($sformatf("%s reg B (R7/R8)", tag), 32'(acc_b), exp_b);
  endtask

  initial begin
    logic [31:0] seed_v;
    seed_v = $urandom(32'd4242);
    rst = 1'b1; upd_en = 1'b1; fb_sel = 1'b0; op_sel = 4'd0;
    src_a = '0; src_b = '0;
    // R8: reset with update enabled clears accumulator
    step(4'd3, 7, 9, 0, 1, 1, "R8");
    step(4'd3, 7, 9, 0, 1, 1, "R8");
    // R1: every entry with zero and all-ones operands
    for (int s = 0; s < 16; s++) step(4'(s), 0, 0, 0, 0, 0, "R1");
    for (int s = 0; s < 16; s++) step(4'(s), 31, 255, 0, 0, 0, "R1");
    // R5: wrap on overflow
    step(4'd1, 31, 255, 0, 1, 0, "R5");
    // R3: negative add from zero
    step(4'd6, 0, 0, 0, 1, 0, "R3");
    step(4'd2, 3, 0, 0, 1, 0, "R3");
    // R4: load ignores operand
    step(4'd13, 9, 200, 0, 1, 0, "R4");
    step(4'd12, 30, 17, 0, 1, 0, "R4");
    // R9: out-of-range constants
    step(4'd8, 1, 1, 0, 1, 0, "R9");
    step(4'd5, 10, 10, 0, 1, 0, "R9");
    step(4'd9, 10, 10, 0, 1, 0, "R9");
    // R6: counter mode via feedback, wraps through all ones
    for (int k = 0; k < 40; k++) step(4'd1, 0, 0, 1, 1, 0, "R6");
    for (int k = 0; k < 12; k++) step(4'd10, 5, 5, 1, 1, 0, "R6");
    // R7: hold with enable low
    for (int k = 0; k < 5; k++) step(4'd3, 11, 11, 1, 0, 0, "R7");
    // R8: reset wins over a pending update
    step(4'd3, 0, 0, 1, 1, 1, "R8");
    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] s;
      string tg;
      s = 4'($urandom_range(0, 15));
      tg = MA[s] ? "R4" : ((CA[s] < 0) ? "R3" : "R2");
      step(s, $urandom, $urandom, 1'($urandom), 1'($urandom), ($urandom_range(0, 63) == 0), tg);
    end
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule